// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status Logic

This block watches the state of a virtual CPU interface and tells the hypervisor when that interface needs attention. Each cycle it evaluates eight maintenance causes and stores the result in an 8-bit status word. The causes are:

- the guest's two group enables;
- the occupancy and pending state of a parameterized set of list registers;
- a nonzero end-of-interrupt count;
- an end-of-interrupt status vector.

Seven causes each have their own enable. The end-of-interrupt cause follows its status vector alone.

The block raises a single registered interrupt line toward the hypervisor when a global enable is set and any cause is active. Software reads the status word as a 32-bit value through a small register port. Writes to the port have no effect. The list registers, the hypervisor control register and prioritization live elsewhere, and their fields arrive here as plain inputs.

Top module: `vmaint_status`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the status word, `maint_irq` and `rdata` are all 0 after that edge.
- R2: Status bit 7 is set when `ie_g1_off` is 1 and `guest_g1_en` is 0. Status bit 6 is set when `ie_g1_on` is 1 and `guest_g1_en` is 1. Otherwise each bit is 0.
- R3: Status bit 5 is set when `ie_g0_off` is 1 and `guest_g0_en` is 0. Status bit 4 is set when `ie_g0_on` is 1 and `guest_g0_en` is 1. Otherwise each bit is 0.
- R4: Status bit 3 is set when `ie_nopend` is 1 and no list entry is pending. Entry i occupies `lr_state[2i+1:2i]`. It counts as pending only when its code is 2'b01. Code 2'b11 (active and pending) is not pending, and neither are 2'b10 (active) and 2'b00 (invalid).
- R5: Status bit 2 is set when `ie_noentry` is 1 and `eoi_count` is nonzero.
- R6: Status bit 1 is set when `ie_under` is 1 and at most one list entry is valid. An entry is valid when its state code is nonzero.
- R7: Status bit 0 is set when any bit of `eoi_status` is 1. No enable applies to this bit.
- R8: `maint_irq` is 1 only when `ctl_en` is 1 and at least one status bit is 1.
- R9: A cycle with `rd_en` high and `addr` equal to 0x010 returns `{24'b0, status}` on `rdata` after the next edge. The value returned is the status held before that edge. Bits 31:8 always read 0. Any other address, or no read, returns 0.
- R10: `wr_en` and `wdata` change neither the status word nor `rdata`.
- R11: The status word and `maint_irq` reflect the inputs sampled at the previous rising edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Global maintenance interrupt enable |
| ie_g1_off | input | 1 | Enable for the group-1-disabled cause |
| ie_g1_on | input | 1 | Enable for the group-1-enabled cause |
| ie_g0_off | input | 1 | Enable for the group-0-disabled cause |
| ie_g0_on | input | 1 | Enable for the group-0-enabled cause |
| ie_nopend | input | 1 | Enable for the no-pending cause |
| ie_noentry | input | 1 | Enable for the entry-not-present cause |
| ie_under | input | 1 | Enable for the underflow cause |
| guest_g0_en | input | 1 | Guest group-0 enable |
| guest_g1_en | input | 1 | Guest group-1 enable |
| lr_state | input | 2*LR_COUNT | State codes of the list entries, 2 bits each |
| eoi_count | input | EOI_CNT_W | End-of-interrupt count |
| eoi_status | input | LR_COUNT | End-of-interrupt status vector |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (ignored) |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data (ignored) |
| rdata | output | DATA_W | Registered read data |
| maint_irq | output | 1 | Maintenance interrupt to the hypervisor |

## Verification
The assertions check on every cycle how each cause bit follows its enable and its condition one edge later. They also check that 2'b11 entries never clear the no-pending bit, that the interrupt needs both the global enable and a live status bit, and that the upper read bits stay zero. The bench's scenarios are needed to show the underflow count boundary at exactly one versus two valid entries, the read latency and the address decode. They also show that writes to the status address leave the readback unchanged.

// File: rtl/vms_pkg.sv
package vms_pkg;

  localparam int STATUS_W = 8;

  // Packed so that the first member lands in bit 7 and the last in bit 0.
  typedef struct packed {
    logic g1_off;   // bit 7
    logic g1_on;    // bit 6
    logic g0_off;   // bit 5
    logic g0_on;    // bit 4
    logic nopend;   // bit 3
    logic noentry;  // bit 2
    logic under;    // bit 1
    logic eoi;      // bit 0
  } status_t;

  localparam logic [1:0] LR_INVALID = 2'b00;
  localparam logic [1:0] LR_PENDING = 2'b01;

endpackage

// File: rtl/vms_lr_scan.sv
module vms_lr_scan #(
  parameter int LR_COUNT = 4
) (
  input  logic [2*LR_COUNT-1:0] lr_state,
  output logic                  any_pending,
  output logic                  few_valid
);
  import vms_pkg::*;

  localparam int CNT_W = $clog2(LR_COUNT + 1);

  logic [LR_COUNT-1:0] pend_vec;
  logic [LR_COUNT-1:0] valid_vec;
  logic [CNT_W-1:0]    valid_cnt;

  for (genvar i = 0; i < LR_COUNT; i++) begin : g_entry
    logic [1:0] code;
    assign code         = lr_state[2*i +: 2];
    assign pend_vec[i]  = (code == LR_PENDING);
    assign valid_vec[i] = (code != LR_INVALID);
  end

  always_comb begin
    valid_cnt = '0;
    for (int i = 0; i < LR_COUNT; i++) begin
      valid_cnt = valid_cnt + CNT_W'(valid_vec[i]);
    end
  end

  assign any_pending = |pend_vec;
  assign few_valid   = (valid_cnt <= CNT_W'(1));

endmodule

// File: rtl/vms_cause_eval.sv
module vms_cause_eval #(
  parameter int LR_COUNT  = 4,
  parameter int EOI_CNT_W = 5
) (
  input  logic                 ie_g1_off,
  input  logic                 ie_g1_on,
  input  logic                 ie_g0_off,
  input  logic                 ie_g0_on,
  input  logic                 ie_nopend,
  input  logic                 ie_noentry,
  input  logic                 ie_under,
  input  logic                 guest_g0_en,
  input  logic                 guest_g1_en,
  input  logic                 any_pending,
  input  logic                 few_valid,
  input  logic [EOI_CNT_W-1:0] eoi_count,
  input  logic [LR_COUNT-1:0]  eoi_status,
  output vms_pkg::status_t     status_d
);

  always_comb begin
    status_d.g1_off  = ie_g1_off  & ~guest_g1_en;
    status_d.g1_on   = ie_g1_on   &  guest_g1_en;
    status_d.g0_off  = ie_g0_off  & ~guest_g0_en;
    status_d.g0_on   = ie_g0_on   &  guest_g0_en;
    status_d.nopend  = ie_nopend  & ~any_pending;
    status_d.noentry = ie_noentry & (eoi_count != '0);
    status_d.under   = ie_under   & few_valid;
    status_d.eoi     = |eoi_status;
  end

endmodule

// File: rtl/vms_read_port.sv
module vms_read_port #(
  parameter int              ADDR_W      = 12,
  parameter int              DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h010
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [vms_pkg::STATUS_W-1:0] status_q,
  output logic [DATA_W-1:0]            rdata
);
  import vms_pkg::*;

  localparam int PAD_W = DATA_W - STATUS_W;

  logic hit;
  assign hit = rd_en && (addr == STATUS_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (hit) begin
      rdata <= {{PAD_W{1'b0}}, status_q};
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/vmaint_status.sv
module vmaint_status #(
  parameter int                LR_COUNT    = 4,
  parameter int                EOI_CNT_W   = 5,
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h010
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctl_en,
  input  logic                  ie_g1_off,
  input  logic                  ie_g1_on,
  input  logic                  ie_g0_off,
  input  logic                  ie_g0_on,
  input  logic                  ie_nopend,
  input  logic                  ie_noentry,
  input  logic                  ie_under,
  input  logic                  guest_g0_en,
  input  logic                  guest_g1_en,
  input  logic [2*LR_COUNT-1:0] lr_state,
  input  logic [EOI_CNT_W-1:0]  eoi_count,
  input  logic [LR_COUNT-1:0]   eoi_status,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  maint_irq
);
  import vms_pkg::*;

  // The status word is read-only, so the write side is left without a sink (R10).
  logic unused_wr;
  assign unused_wr = ^{wr_en, wdata};

  logic                any_pending;
  logic                few_valid;
  status_t             status_d;
  logic [STATUS_W-1:0] status_q;

  vms_lr_scan #(.LR_COUNT(LR_COUNT)) u_scan (
    .lr_state    (lr_state),
    .any_pending (any_pending),
    .few_valid   (few_valid)
  );

  vms_cause_eval #(.LR_COUNT(LR_COUNT), .EOI_CNT_W(EOI_CNT_W)) u_eval (
    .ie_g1_off   (ie_g1_off),
    .ie_g1_on    (ie_g1_on),
    .ie_g0_off   (ie_g0_off),
    .ie_g0_on    (ie_g0_on),
    .ie_nopend   (ie_nopend),
    .ie_noentry  (ie_noentry),
    .ie_under    (ie_under),
    .guest_g0_en (guest_g0_en),
    .guest_g1_en (guest_g1_en),
    .any_pending (any_pending),
    .few_valid   (few_valid),
    .eoi_count   (eoi_count),
    .eoi_status  (eoi_status),
    .status_d    (status_d)
  );

  // Status and interrupt are registered from the same sampled inputs (R11).
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      maint_irq <= 1'b0;
    end else begin
      status_q  <= status_d;
      maint_irq <= ctl_en & (|status_d);
    end
  end

  vms_read_port #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .status_q (status_q),
    .rdata    (rdata)
  );

endmodule

// File: rtl/vms_checker.sv
module vms_checker #(
  parameter int LR_COUNT  = 4,
  parameter int EOI_CNT_W = 5,
  parameter int DATA_W    = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ctl_en,
  input logic                  ie_g1_off,
  input logic                  ie_g1_on,
  input logic                  ie_g0_off,
  input logic                  ie_g0_on,
  input logic                  ie_nopend,
  input logic                  ie_noentry,
  input logic [2*LR_COUNT-1:0] lr_state,
  input logic                  guest_g0_en,
  input logic                  guest_g1_en,
  input logic [EOI_CNT_W-1:0]  eoi_count,
  input logic [LR_COUNT-1:0]   eoi_status,
  input logic                  rd_en,
  input logic                  wr_en,
  input logic [7:0]            status_q,
  input logic [DATA_W-1:0]     rdata,
  input logic                  maint_irq
);

  logic seen_pending;
  always_comb begin
    seen_pending = 1'b0;
    for (int i = 0; i < LR_COUNT; i++) begin
      if (lr_state[2*i +: 2] == 2'b01) seen_pending = 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (status_q == 8'h00 && !maint_irq && rdata == '0));

  assert_g1_on_R2: assert property (@(posedge clk) disable iff (rst)
    (ie_g1_on && guest_g1_en) |=> status_q[6]);
  assert_g1_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!ie_g1_off || guest_g1_en) |=> !status_q[7]);

  assert_g0_on_R3: assert property (@(posedge clk) disable iff (rst)
    (ie_g0_on && guest_g0_en) |=> status_q[4]);
  assert_g0_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!ie_g0_off || guest_g0_en) |=> !status_q[5]);

  assert_nopend_set_R4: assert property (@(posedge clk) disable iff (rst)
    (ie_nopend && !seen_pending) |=> status_q[3]);
  assert_nopend_clear_R4: assert property (@(posedge clk) disable iff (rst)
    seen_pending |=> !status_q[3]);

  assert_noentry_R5: assert property (@(posedge clk) disable iff (rst)
    (ie_noentry && eoi_count != '0) |=> status_q[2]);

  assert_eoi_set_R7: assert property (@(posedge clk) disable iff (rst)
    (|eoi_status) |=> status_q[0]);
  assert_eoi_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi_status == '0) |=> !status_q[0]);

  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (rst)
    maint_irq |-> (status_q != 8'h00));
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !maint_irq);

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:8] == '0);

  assert_write_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> (rdata == '0));

endmodule

bind vmaint_status vms_checker #(
  .LR_COUNT  (LR_COUNT),
  .EOI_CNT_W (EOI_CNT_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_en      (ctl_en),
  .ie_g1_off   (ie_g1_off),
  .ie_g1_on    (ie_g1_on),
  .ie_g0_off   (ie_g0_off),
  .ie_g0_on    (ie_g0_on),
  .ie_nopend   (ie_nopend),
  .ie_noentry  (ie_noentry),
  .lr_state    (lr_state),
  .guest_g0_en (guest_g0_en),
  .guest_g1_en (guest_g1_en),
  .eoi_count   (eoi_count),
  .eoi_status  (eoi_status),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .status_q    (status_q),
  .rdata       (rdata),
  .maint_irq   (maint_irq)
);

// File: tb/vmaint_status_tb.sv
module vmaint_status_tb;

  localparam int N  = 4;
  localparam int EW = 5;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] STAT_A = 12'h010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_en = 0, ie_g1_off = 0, ie_g1_on = 0, ie_g0_off = 0, ie_g0_on = 0;
  logic ie_nopend = 0, ie_noentry = 0, ie_under = 0, guest_g0_en = 0, guest_g1_en = 0;
  logic [2*N-1:0] lr_state = '0;
  logic [EW-1:0]  eoi_count = '0;
  logic [N-1:0]   eoi_status = '0;
  logic           rd_en = 0, wr_en = 0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic           maint_irq;

  always #2 clk = ~clk;  // 250 MHz

  vmaint_status #(.LR_COUNT(N), .EOI_CNT_W(EW), .ADDR_W(AW), .DATA_W(DW),
                  .STATUS_ADDR(STAT_A)) u_dut (
    .clk(clk), .rst(rst), .ctl_en(ctl_en),
    .ie_g1_off(ie_g1_off), .ie_g1_on(ie_g1_on), .ie_g0_off(ie_g0_off),
    .ie_g0_on(ie_g0_on), .ie_nopend(ie_nopend), .ie_noentry(ie_noentry),
    .ie_under(ie_under), .guest_g0_en(guest_g0_en), .guest_g1_en(guest_g1_en),
    .lr_state(lr_state), .eoi_count(eoi_count), .eoi_status(eoi_status),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .maint_irq(maint_irq)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Behavioural reference model, updated at each rising edge.
  logic [7:0]    m_status = '0;
  logic          m_irq = 0;
  logic [DW-1:0] m_rdata = '0;
  bit            m_in_reset = 1;

  function automatic logic [7:0] causes();
    int pend = 0;
    int valid = 0;
    logic [7:0] s;
    for (int i = 0; i < N; i++) begin
      if (lr_state[2*i +: 2] == 2'b01) pend++;
      if (lr_state[2*i +: 2] != 2'b00) valid++;
    end
    s[7] = ie_g1_off && !guest_g1_en;
    s[6] = ie_g1_on && guest_g1_en;
    s[5] = ie_g0_off && !guest_g0_en;
    s[4] = ie_g0_on && guest_g0_en;
    s[3] = ie_nopend && (pend == 0);
    s[2] = ie_noentry && (eoi_count != 0);
    s[1] = ie_under && (valid <= 1);
    s[0] = (eoi_status != 0);
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_status = '0; m_irq = 0; m_rdata = '0; m_in_reset = 1;
    end else begin
      logic [7:0] s;
      m_in_reset = 0;
      m_rdata = (rd_en && addr == STAT_A) ? {24'h0, m_status} : '0;
      s = causes();
      m_status = s;
      m_irq = ctl_en && (s != 0);
    end
  end

  function automatic string bit_tag(int b);
    case (b)
      7, 6: return "R2";
      5, 4: return "R3";
      3: return "R4";
      2: return "R5";
      1: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output against the model, away from the rising edge.
  task automatic tick();
    @(negedge clk);
    if (m_in_reset) begin
      check("R1 rdata", rdata, '0);
      check("R1 irq", {31'b0, maint_irq}, '0);
    end else begin
      for (int b = 0; b < 8; b++)
        check(bit_tag(b), {31'b0, rdata[b]}, {31'b0, m_rdata[b]});
      check("R9 upper", {8'b0, rdata[DW-1:8]}, {8'b0, m_rdata[DW-1:8]});
      check("R8 irq", {31'b0, maint_irq}, {31'b0, m_irq});
    end
  endtask

  task automatic clear_in();
    {ctl_en, ie_g1_off, ie_g1_on, ie_g0_off, ie_g0_on} = '0;
    {ie_nopend, ie_noentry, ie_under, guest_g0_en, guest_g1_en} = '0;
    lr_state = '0; eoi_count = '0; eoi_status = '0;
    wr_en = 0; wdata = '0; rd_en = 1; addr = STAT_A;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    clear_in();
    tick(); tick(); tick();  // R1 reset state
    rst = 0;
    tick(); tick();

    // R11: one input change, irq follows after exactly one edge
    ctl_en = 1; eoi_status = 4'b0100;
    tick();
    check("R11 irq after one edge", {31'b0, maint_irq}, 32'd1);
    eoi_status = '0;
    tick();
    check("R11 irq drops after one edge", {31'b0, maint_irq}, 32'd0);

    // R4: all entries active+pending do not count as pending
    ie_nopend = 1; lr_state = 8'b11_11_11_11;
    tick(); tick();
    check("R4 0b11 not pending", {24'b0, rdata[7:0]}, 32'h08);
    lr_state = 8'b11_01_11_11;
    tick(); tick();
    check("R4 one pending clears bit", {24'b0, rdata[7:0]}, 32'h00);
    ie_nopend = 0;

    // R6: boundary one valid vs two valid
    ie_under = 1; lr_state = 8'b00_00_10_00;
    tick(); tick();
    check("R6 one valid", {24'b0, rdata[7:0]}, 32'h02);
    lr_state = 8'b00_11_10_00;
    tick(); tick();
    check("R6 two valid", {24'b0, rdata[7:0]}, 32'h00);
    lr_state = '0;
    tick(); tick();
    check("R6 zero valid", {24'b0, rdata[7:0]}, 32'h02);
    ie_under = 0;

    // R2/R3 group patterns, R5 count boundary
    ie_g1_off = 1; ie_g0_on = 1; guest_g0_en = 1; eoi_count = 5'd1; ie_noentry = 1;
    tick(); tick();
    check("R2 R3 R5 mix", {24'b0, rdata[7:0]}, 32'h94);
    guest_g1_en = 1; ie_g1_on = 1; guest_g0_en = 0; ie_g0_off = 1; eoi_count = 0;
    tick(); tick();
    check("R2 R3 R5 swap", {24'b0, rdata[7:0]}, 32'h60);

    // R8: global enable off keeps irq low with live status
    ctl_en = 0;
    tick(); tick();
    check("R8 gated", {31'b0, maint_irq}, 32'd0);
    ctl_en = 1;

    // R9: other address and no read return zero
    addr = 12'h014;
    tick(); tick();
    check("R9 other addr", rdata, '0);
    rd_en = 0; addr = STAT_A;
    tick();
    check("R9 no read", rdata, '0);

    // R10: writes of all ones to the status address change nothing
    wr_en = 1; wdata = '1;
    tick();
    check("R10 write only", rdata, '0);
    rd_en = 1;
    tick(); tick();
    check("R10 readback", rdata, 32'h60);
    wr_en = 0;

    // Random traffic compared each cycle
    for (int k = 0; k < 3000; k++) begin
      {ctl_en, ie_g1_off, ie_g1_on, ie_g0_off, ie_g0_on} = 5'($urandom);
      {ie_nopend, ie_noentry, ie_under, guest_g0_en, guest_g1_en} = 5'($urandom);
      lr_state   = 8'($urandom);
      eoi_count  = ($urandom % 4 == 0) ? 5'($urandom) : '0;
      eoi_status = ($urandom % 3 == 0) ? 4'($urandom) : '0;
      rd_en = ($urandom % 8 != 0);
      addr  = ($urandom % 6 == 0) ? 12'($urandom) : STAT_A;
      wr_en = $urandom % 2; wdata = $urandom;
      rst   = ($urandom % 500 == 0);
      tick();
    end
    rst = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule